// File: doc/BRIEF.md
# Clock-Sampled Static Memory Core

This block models a 2048-word, 8-bit static memory in synthesizable logic. It has three active-low controls (select, write strobe and output drive) and a data bus that is split into a data-in port, a data-out port and a drive-enable flag. The enclosing logic combines these three signals into a tri-state pad. All controls, the address and the input data are sampled on the rising edge of a fast internal clock. The access time is a parameter counted in clock cycles.

A word is written while select and write strobe are both low. The write is committed on the edge where that overlap ends, whichever of the two signals rises to end it. A read runs whenever select is low and the write strobe is high. The addressed word reaches the data-out port a fixed number of edges after the address is applied. The drive flag is only raised for a read with output drive asserted. Because of this, the strobe orderings around a write never drive the bus.

Top module: `sram_core`

## Requirements
- R1: The store holds 2048 independent 8-bit words selected by an 11-bit address. A word written at one address does not change any other address.
- R2: With `sel_n`=0 and `wr_n`=1 held, `rdata` equals the stored word at `addr` after the LATENCY-th rising edge following the address change. The value has the same polarity as the value written.
- R3: After an address change during a read, `rdata` keeps its previous value through the first LATENCY-1 rising edges.
- R4: `drive` is 1 one edge after an edge that samples `sel_n`=0, `wr_n`=1 and `oe_n`=0. It is 0 one edge after any edge that samples `sel_n`=1, `oe_n`=1 or `wr_n`=0.
- R5: No word changes unless `sel_n` and `wr_n` are sampled low on the same edge. `wr_n` low with `sel_n` high leaves memory unchanged.
- R6: A write stores the `wdata` sampled on the edge where the overlap ends, at the address sampled on the last edge inside the overlap. Changes to `wdata` earlier in the window have no effect.
- R7: The overlap ends, and commits, when `wr_n` rises first, when `sel_n` rises first, or when both rise on the same edge.
- R8: If `wr_n` falls before or on the same edge as `sel_n`, `drive` stays 0 for the whole write.
- R9: If `sel_n` rises before or on the same edge as `wr_n`, `drive` stays 0 at the end of the write.
- R10: While `rst` is high, and on the edge after it, `rdata` is 0 and `drive` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output drive |
| addr | input | 11 | Word address |
| wdata | input | 8 | Data from the bus |
| rdata | output | 8 | Data toward the bus |
| drive | output | 1 | Bus drive enable; high-impedance when 0 |

## Verification
A wrong address capture or a wrong commit edge shows up as a stale or misplaced word. The error is only visible when that address is read back, which can be thousands of cycles later. The full write sweep followed by a full read sweep is therefore what exposes it. A wrong drive decode shows on `drive` one edge after the offending control pattern. A miscounted latency shows as early or late data on the very read that follows an address change.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int WORDS_DEF = 2048;
    localparam int DATA_W_DEF = 8;

    typedef struct packed {
        logic in_write;   // select and strobe both low
        logic do_read;    // select low, strobe high
        logic drive_req;  // read with output drive asserted
    } ctrl_t;

    function automatic ctrl_t decode(input logic sel_n, input logic wr_n,
                                     input logic oe_n);
        ctrl_t c;
        c.in_write  = !sel_n && !wr_n;
        c.do_read   = !sel_n && wr_n;
        c.drive_req = c.do_read && !oe_n;
        return c;
    endfunction
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic          drive_q
);
    ctrl_t          cur;
    logic           win_q;
    logic [AW-1:0]  win_addr_q;

    always_comb cur = decode(sel_n, wr_n, oe_n);

    // overlap seen last edge and gone now: this edge ends the window
    assign commit      = win_q && !cur.in_write;
    assign commit_addr = win_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q      <= 1'b0;
            win_addr_q <= '0;
            drive_q    <= 1'b0;
        end else begin
            win_q   <= cur.in_write;
            drive_q <= cur.drive_req;
            if (cur.in_write) win_addr_q <= addr;
        end
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= mem[raddr];
    end
endmodule

// File: rtl/sram_rdpipe.sv
module sram_rdpipe #(
    parameter int DW    = 8,
    parameter int EXTRA = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out
);
    generate
        if (EXTRA == 0) begin : g_pass
            assign d_out = d_in;
        end else begin : g_shift
            logic [DW-1:0] stage [EXTRA];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < EXTRA; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= d_in;
                    for (int i = 1; i < EXTRA; i++) stage[i] <= stage[i-1];
                end
            end
            assign d_out = stage[EXTRA-1];
        end
    endgenerate
endmodule

// File: rtl/sram_core.sv
module sram_core
    import sram_pkg::*;
#(
    parameter int WORDS   = WORDS_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int LATENCY = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel_n,
    input  logic                     wr_n,
    input  logic                     oe_n,
    input  logic [$clog2(WORDS)-1:0] addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     drive
);
    localparam int AW = $clog2(WORDS);

    logic          commit;
    logic [AW-1:0] commit_addr;
    logic [DATA_W-1:0] arr_q;

    sram_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
        .addr(addr), .commit(commit), .commit_addr(commit_addr),
        .drive_q(drive)
    );

    sram_array #(.AW(AW), .DW(DATA_W)) u_array (
        .clk(clk), .rst(rst), .we(commit), .waddr(commit_addr),
        .wdata(wdata), .raddr(addr), .rdata_q(arr_q)
    );

    sram_rdpipe #(.DW(DATA_W), .EXTRA(LATENCY-1)) u_pipe (
        .clk(clk), .rst(rst), .d_in(arr_q), .d_out(rdata)
    );
endmodule

// File: rtl/sram_core_chk.sv
module sram_core_chk (
    input logic clk,
    input logic rst,
    input logic sel_n,
    input logic wr_n,
    input logic oe_n,
    input logic drive
);
    // R4
    drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && wr_n && !oe_n) |=> drive);
    // R4
    drive_off_oe_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !drive);
    // R8
    no_drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> !drive);
    // R9
    no_drive_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !drive);
endmodule

bind sram_core sram_core_chk u_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .drive(drive)
);

// File: tb/sram_core_test.sv
module sram_core_test;
    localparam int WORDS = 2048;
    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int LAT   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          drive;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [WORDS];

    always #2 clk = ~clk;

    sram_core #(.WORDS(WORDS), .DATA_W(DW), .LATENCY(LAT)) uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .drive(drive)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37) ^ (a >> 3) ^ 8'h5A);
    endfunction

    // mode 0: strobe rises first, 1: select rises first, 2: both together
    task automatic write_word(input int a, input logic [DW-1:0] d,
                              input int mode);
        addr = AW'(a); wdata = d; sel_n = 1'b0; wr_n = 1'b0;
        tick();
        if (mode == 0) wr_n = 1'b1;
        else if (mode == 1) sel_n = 1'b1;
        else begin sel_n = 1'b1; wr_n = 1'b1; end
        tick();
        sel_n = 1'b1; wr_n = 1'b1;
        model[a] = d;
    endtask

    task automatic read_check(input int a, input string req);
        addr = AW'(a); sel_n = 1'b0; wr_n = 1'b1; oe_n = 1'b0;
        repeat (LAT) tick();
        check(req, 32'(rdata), 32'(model[a]));
    endtask

    initial begin
        repeat (3) tick();
        // R10 during reset
        check("R10 rdata in reset", 32'(rdata), 0);
        check("R10 drive in reset", 32'(drive), 0);
        rst = 1'b0;
        tick();
        check("R10 drive after reset", 32'(drive), 0);

        // R1 R7: full write sweep with all three ending orders
        for (int a = 0; a < WORDS; a++) write_word(a, pat(a), a % 3);

        // R1 R2 R3: full read sweep, select held low across address changes
        addr = '0; sel_n = 1'b0; wr_n = 1'b1; oe_n = 1'b0;
        repeat (LAT) tick();
        for (int a = 0; a < WORDS; a++) begin
            logic [DW-1:0] prev;
            prev = rdata;
            addr = AW'(a);
            repeat (LAT - 1) tick();
            check("R3 hold old word", 32'(rdata), 32'(prev));
            tick();
            check("R1 R2 word readback", 32'(rdata), 32'(pat(a)));
        end

        // R4: drive decode
        oe_n = 1'b1; tick();
        check("R4 drive off with oe_n high", 32'(drive), 0);
        oe_n = 1'b0; tick();
        check("R4 drive on for read", 32'(drive), 1);
        sel_n = 1'b1; tick();
        check("R4 drive off deselected", 32'(drive), 0);

        // R5: strobe low alone writes nothing
        addr = 11'd100; wdata = ~pat(100); sel_n = 1'b1; wr_n = 1'b0;
        repeat (3) tick();
        wr_n = 1'b1; tick();
        read_check(100, "R5 strobe alone no write");
        // R5: select low alone (a read) writes nothing
        addr = 11'd101; wdata = ~pat(101); repeat (3) tick();
        sel_n = 1'b1; tick();
        read_check(101, "R5 select alone no write");

        // R6: wdata changes inside window, end value committed
        sel_n = 1'b1; tick();
        addr = 11'd200; wdata = 8'h11; sel_n = 1'b0; wr_n = 1'b0;
        tick(); wdata = 8'h22; tick(); wdata = 8'h33; tick();
        wdata = 8'hC4; wr_n = 1'b1;
        tick();
        model[200] = 8'hC4;
        // R4 R7: strobe rose first with oe low -> now a read, drive on
        check("R4 R7 drive after strobe-first end", 32'(drive), 1);
        repeat (LAT) tick();
        check("R6 end-edge data committed", 32'(rdata), 32'(8'hC4));
        read_check(199, "R1 neighbour untouched");

        // R8: strobe falls before select, then together
        sel_n = 1'b1; wr_n = 1'b1; tick();
        addr = 11'd300; wdata = 8'hA7; wr_n = 1'b0; tick();
        check("R8 drive strobe first", 32'(drive), 0);
        sel_n = 1'b0; tick();
        check("R8 drive in overlap", 32'(drive), 0);
        tick();
        check("R8 drive still off", 32'(drive), 0);
        // R9: select rises before strobe
        sel_n = 1'b1; tick();
        check("R9 drive select first", 32'(drive), 0);
        wr_n = 1'b1; tick();
        check("R9 drive after strobe", 32'(drive), 0);
        model[300] = 8'hA7;
        read_check(300, "R7 select-first commit");
        // R8 R9: both fall together, both rise together
        sel_n = 1'b1; tick();
        addr = 11'd301; wdata = 8'h3C; sel_n = 1'b0; wr_n = 1'b0; tick();
        check("R8 drive simultaneous fall", 32'(drive), 0);
        sel_n = 1'b1; wr_n = 1'b1; tick();
        check("R9 drive simultaneous rise", 32'(drive), 0);
        model[301] = 8'h3C;
        read_check(301, "R7 simultaneous commit");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule